// File: doc/BRIEF.md
# Floating-Point Control/Status Register Execute Unit

This block sits next to the integer pipeline and carries out the control-register instructions that address the floating-point status state: the accrued exception flags, the dynamic rounding mode and the combined view of both. Each cycle it may receive one instruction word with the system major opcode, together with the value of the source register. It decodes the operation, forms the new register value by write, bit-set or bit-clear, and returns the previous value for the destination register in the same cycle. The state update lands on the next clock edge.

The unit keeps the 3-bit rounding mode exactly as software wrote it, reserved codes included. It also holds a separate copy for the floating-point datapath that only ever takes legal rounding codes, and it raises a flag while the stored mode is reserved. Exception flags reported by the floating-point unit are accumulated every cycle. Instructions it cannot handle are reported as illegal and leave all state alone.

Top module: `fpcsr_unit`

## Requirements
- R1: An instruction is accepted when `valid_i` is high, bits 6:0 equal 1110011, and bits 13:12 are non-zero. Bits 13:12 choose the operation: 01 writes the operand, 10 sets the operand's bits, 11 clears them. The destination index is bits 11:7 and the register address is bits 31:20.
- R2: When bit 14 is 0, the operand is `rs1_val_i`, or zero if the source index in bits 19:15 is 0. When bit 14 is 1, the operand is bits 19:15 zero-extended.
- R3: The new value is the operand for write, the old value OR the operand for set, and the old value AND NOT the operand for clear. The old value appears on `rd_data_o` in the same cycle. The state changes on the next rising edge.
- R4: Address 0x001 reads the flags in bits 4:0. Address 0x002 reads the rounding mode in bits 2:0. Address 0x003 reads the mode in bits 7:5 and the flags in bits 4:0, with flag order NV, DZ, OF, UF, NX from bit 4 down. All other read bits are zero, and operand bits above the addressed field are ignored.
- R5: `rd_we_o` stays low when the destination index is 0. The state update still happens.
- R6: A non-system opcode, bits 13:12 equal to 00, or an address other than 0x001 to 0x003 raises `illegal_insn_o`. In that case `rd_we_o` stays low and the stored mode and flags do not change, apart from the accrual in R9.
- R7: The stored rounding mode keeps all three bits, including 101, 110 and 111. `rm_o` takes a newly written mode only when that mode is 100 or less; otherwise `rm_o` holds its value. The codes are 000 nearest-even, 001 toward zero, 010 down, 011 up, 100 nearest-max.
- R8: `illegal_rm_o` is high exactly while the stored rounding mode is 101, 110 or 111.
- R9: `fpu_flags_i` is ORed into the flags on every rising edge. If an instruction writes address 0x001 or 0x003 in the same cycle, the written value wins and that cycle's accrual is dropped.
- R10: After reset the stored mode, the flags and `rm_o` are all zero, and `illegal_rm_o` is low.
- R11: With the mode at 001: a write of 2 leaves mode 2; a set-immediate of 2 leaves mode 3; a clear-immediate of 1 leaves mode 0. Each of these returns 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Instruction present this cycle |
| insn_i | input | 32 | Instruction word |
| rs1_val_i | input | XLEN | Source register value |
| fpu_flags_i | input | 5 | Exception flags raised by the FPU this cycle |
| rd_we_o | output | 1 | Destination register write enable |
| rd_idx_o | output | 5 | Destination register index |
| rd_data_o | output | XLEN | Previous register value, zero-extended |
| illegal_insn_o | output | 1 | Instruction not handled by this unit |
| rm_o | output | 3 | Rounding mode for the FPU datapath, always legal |
| illegal_rm_o | output | 1 | Stored rounding mode is a reserved code |

## Verification
The three operations are applied to each of the three addresses, in both the register form and the immediate form. This separates the operand selection from the read-modify-write formula. Source index 0 is paired with a non-zero register value to show the forced zero. An operand wider than the field shows that the upper bits are ignored. Reserved rounding codes are written and then read back, which tells the stored mode apart from the gated `rm_o`. Flags are injected both on idle cycles and in the same cycle as a flags write, which separates plain accrual from write priority. Illegal encodings are followed by read-back to show that no state moved.

// File: rtl/fpcsr_pkg.sv
package fpcsr_pkg;

  localparam int FLAG_W = 5;
  localparam int RM_W   = 3;
  localparam int CSR_W  = FLAG_W + RM_W;

  localparam logic [6:0]      SYSTEM_OPC    = 7'b1110011;
  localparam logic [11:0]     ADDR_FLAGS    = 12'h001;
  localparam logic [11:0]     ADDR_RM       = 12'h002;
  localparam logic [11:0]     ADDR_ALL      = 12'h003;
  localparam logic [RM_W-1:0] RM_LAST_LEGAL = 3'b100;

  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_WRITE = 2'b01,
    OP_SET   = 2'b10,
    OP_CLEAR = 2'b11
  } csr_op_e;

  typedef enum logic [1:0] {
    SEL_NONE  = 2'b00,
    SEL_FLAGS = 2'b01,
    SEL_RM    = 2'b10,
    SEL_ALL   = 2'b11
  } csr_sel_e;

  typedef struct packed {
    csr_op_e     op;
    logic        use_imm;
    logic [4:0]  rd;
    logic [4:0]  src;
    logic [11:0] addr;
    logic [6:0]  opc;
  } csr_dec_t;

  function automatic logic [CSR_W-1:0] csr_rmw(csr_op_e op, logic [CSR_W-1:0] old_v,
                                                logic [CSR_W-1:0] opnd);
    case (op)
      OP_WRITE: csr_rmw = opnd;
      OP_SET:   csr_rmw = old_v | opnd;
      OP_CLEAR: csr_rmw = old_v & ~opnd;
      default:  csr_rmw = old_v;
    endcase
  endfunction

  function automatic logic rm_is_legal(logic [RM_W-1:0] rm);
    rm_is_legal = (rm <= RM_LAST_LEGAL);
  endfunction

endpackage

// File: rtl/fpcsr_decode.sv
module fpcsr_decode
  import fpcsr_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [31:0]      insn_i,
  input  logic [XLEN-1:0]  rs1_val_i,
  output csr_dec_t         dec_o,
  output csr_sel_e         sel_o,
  output logic             legal_o,
  output logic [CSR_W-1:0] opnd_o
);

  always_comb begin
    dec_o.opc     = insn_i[6:0];
    dec_o.rd      = insn_i[11:7];
    dec_o.op      = csr_op_e'(insn_i[13:12]);
    dec_o.use_imm = insn_i[14];
    dec_o.src     = insn_i[19:15];
    dec_o.addr    = insn_i[31:20];
  end

  always_comb begin
    case (dec_o.addr)
      ADDR_FLAGS: sel_o = SEL_FLAGS;
      ADDR_RM:    sel_o = SEL_RM;
      ADDR_ALL:   sel_o = SEL_ALL;
      default:    sel_o = SEL_NONE;
    endcase
  end

  assign legal_o = (dec_o.opc == SYSTEM_OPC) && (dec_o.op != OP_NONE) && (sel_o != SEL_NONE);

  always_comb begin
    if (dec_o.use_imm)
      opnd_o = {{(CSR_W-5){1'b0}}, dec_o.src};
    else if (dec_o.src == 5'd0)
      opnd_o = '0;
    else
      opnd_o = rs1_val_i[CSR_W-1:0];
  end

endmodule

// File: rtl/fpcsr_state.sv
module fpcsr_state
  import fpcsr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  csr_sel_e          sel_i,
  input  logic [CSR_W-1:0]  new_val_i,
  input  logic [FLAG_W-1:0] fpu_flags_i,
  output logic [RM_W-1:0]   frm_q_o,
  output logic [FLAG_W-1:0] fflags_q_o,
  output logic [RM_W-1:0]   host_rm_q_o,
  output logic              frm_wr_o,
  output logic              flags_wr_o,
  output logic              rm_update_o,
  output logic [RM_W-1:0]   frm_next_o
);

  assign frm_wr_o    = wr_en_i && (sel_i == SEL_RM || sel_i == SEL_ALL);
  assign flags_wr_o  = wr_en_i && (sel_i == SEL_FLAGS || sel_i == SEL_ALL);
  assign frm_next_o  = (sel_i == SEL_RM) ? new_val_i[RM_W-1:0] : new_val_i[CSR_W-1:FLAG_W];
  assign rm_update_o = frm_wr_o && rm_is_legal(frm_next_o);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frm_q_o     <= '0;
      fflags_q_o  <= '0;
      host_rm_q_o <= '0;
    end else begin
      if (frm_wr_o) frm_q_o <= frm_next_o;
      if (rm_update_o) host_rm_q_o <= frm_next_o;
      if (flags_wr_o) fflags_q_o <= new_val_i[FLAG_W-1:0];
      else            fflags_q_o <= fflags_q_o | fpu_flags_i;
    end
  end

endmodule

// File: rtl/fpcsr_unit.sv
module fpcsr_unit
  import fpcsr_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  input  logic [31:0]       insn_i,
  input  logic [XLEN-1:0]   rs1_val_i,
  input  logic [4:0]        fpu_flags_i,
  output logic              rd_we_o,
  output logic [4:0]        rd_idx_o,
  output logic [XLEN-1:0]   rd_data_o,
  output logic              illegal_insn_o,
  output logic [2:0]        rm_o,
  output logic              illegal_rm_o
);

  csr_dec_t         dec;
  csr_sel_e         sel;
  logic             legal;
  logic [CSR_W-1:0] opnd;
  logic [CSR_W-1:0] old_val;
  logic [CSR_W-1:0] new_val;
  logic             csr_commit;
  logic [RM_W-1:0]  frm_q;
  logic [FLAG_W-1:0] fflags_q;
  logic [RM_W-1:0]  host_rm_q;
  logic             frm_wr;
  logic             flags_wr;
  logic             rm_update;
  logic [RM_W-1:0]  frm_next;

  fpcsr_decode #(.XLEN(XLEN)) u_decode (
    .insn_i    (insn_i),
    .rs1_val_i (rs1_val_i),
    .dec_o     (dec),
    .sel_o     (sel),
    .legal_o   (legal),
    .opnd_o    (opnd)
  );

  always_comb begin
    case (sel)
      SEL_FLAGS: old_val = {{RM_W{1'b0}}, fflags_q};
      SEL_RM:    old_val = {{FLAG_W{1'b0}}, frm_q};
      SEL_ALL:   old_val = {frm_q, fflags_q};
      default:   old_val = '0;
    endcase
  end

  assign csr_commit = valid_i && legal;
  assign new_val    = csr_rmw(dec.op, old_val, opnd);

  fpcsr_state u_state (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en_i     (csr_commit),
    .sel_i       (sel),
    .new_val_i   (new_val),
    .fpu_flags_i (fpu_flags_i),
    .frm_q_o     (frm_q),
    .fflags_q_o  (fflags_q),
    .host_rm_q_o (host_rm_q),
    .frm_wr_o    (frm_wr),
    .flags_wr_o  (flags_wr),
    .rm_update_o (rm_update),
    .frm_next_o  (frm_next)
  );

  assign rd_we_o        = csr_commit && (dec.rd != 5'd0);
  assign rd_idx_o       = dec.rd;
  assign rd_data_o      = {{(XLEN-CSR_W){1'b0}}, old_val};
  assign illegal_insn_o = valid_i && !legal;
  assign rm_o           = host_rm_q;
  assign illegal_rm_o   = !rm_is_legal(frm_q);

endmodule

// File: rtl/fpcsr_unit_checker.sv
module fpcsr_unit_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [4:0] fpu_flags_i,
  input logic       rd_we_o,
  input logic [4:0] rd_idx_o,
  input logic       illegal_insn_o,
  input logic [2:0] rm_o,
  input logic       illegal_rm_o,
  input logic [2:0] frm_q,
  input logic [4:0] fflags_q,
  input logic       frm_wr,
  input logic       flags_wr,
  input logic [2:0] frm_next
);

  AST_ILLEGAL_NO_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_insn_o |-> (!rd_we_o && !frm_wr && !flags_wr)); // R6

  AST_RD_ZERO_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    rd_we_o |-> (rd_idx_o != 5'd0)); // R5

  AST_RM_OUT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    rm_o <= 3'd4); // R7

  AST_RM_HELD_ON_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_wr && frm_next > 3'd4) |=> $stable(rm_o)); // R7

  AST_FRM_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_wr |=> $stable(frm_q)); // R7

  AST_RESERVED_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    frm_wr |=> (illegal_rm_o == ($past(frm_next) > 3'd4))); // R8

  AST_FLAGS_ACCRUE: assert property (@(posedge clk) disable iff (!rst_n)
    !flags_wr |=> (fflags_q == ($past(fflags_q) | $past(fpu_flags_i)))); // R9

endmodule

bind fpcsr_unit fpcsr_unit_checker u_checker (
  .clk            (clk),
  .rst_n          (rst_n),
  .fpu_flags_i    (fpu_flags_i),
  .rd_we_o        (rd_we_o),
  .rd_idx_o       (rd_idx_o),
  .illegal_insn_o (illegal_insn_o),
  .rm_o           (rm_o),
  .illegal_rm_o   (illegal_rm_o),
  .frm_q          (frm_q),
  .fflags_q       (fflags_q),
  .frm_wr         (frm_wr),
  .flags_wr       (flags_wr),
  .frm_next       (frm_next)
);

// File: tb/fpcsr_unit_bench.sv
`timescale 1ns/1ps
module fpcsr_unit_bench;

  localparam int XLEN = 64;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            valid_i = 1'b0;
  logic [31:0]     insn_i = '0;
  logic [XLEN-1:0] rs1_val_i = '0;
  logic [4:0]      fpu_flags_i = '0;
  logic            rd_we_o;
  logic [4:0]      rd_idx_o;
  logic [XLEN-1:0] rd_data_o;
  logic            illegal_insn_o;
  logic [2:0]      rm_o;
  logic            illegal_rm_o;

  always #10 clk = ~clk;

  fpcsr_unit #(.XLEN(XLEN)) u_fpcsr_unit (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .insn_i(insn_i),
    .rs1_val_i(rs1_val_i), .fpu_flags_i(fpu_flags_i), .rd_we_o(rd_we_o),
    .rd_idx_o(rd_idx_o), .rd_data_o(rd_data_o), .illegal_insn_o(illegal_insn_o),
    .rm_o(rm_o), .illegal_rm_o(illegal_rm_o)
  );

  typedef struct {
    logic            we;
    logic [4:0]      idx;
    logic [XLEN-1:0] data;
    logic            ill;
    string           tag;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   errors = 0;
  bit   done = 0;

  logic [2:0] m_frm = '0;
  logic [4:0] m_flags = '0;
  logic [2:0] m_rm = '0;

  function automatic logic [31:0] enc(logic [11:0] a, logic [4:0] s, logic [2:0] f3, logic [4:0] rd);
    return {a, s, f3, rd, 7'h73};
  endfunction

  task automatic check(string tag, string what, logic [63:0] act, logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  task automatic issue(string tag, logic [31:0] insn, logic [XLEN-1:0] rs1v, logic [4:0] flags);
    exp_t e;
    logic [2:0]  f3;
    logic [11:0] a;
    logic [4:0]  s;
    logic        ok;
    logic [7:0]  oldv, opnd, nv;
    f3 = insn[14:12];
    a  = insn[31:20];
    s  = insn[19:15];
    ok = (insn[6:0] == 7'h73) && (f3[1:0] != 2'b00) && (a >= 12'h1) && (a <= 12'h3);
    oldv = (a == 12'h1) ? {3'b0, m_flags} : (a == 12'h2) ? {5'b0, m_frm} : {m_frm, m_flags};
    opnd = f3[2] ? {3'b0, s} : ((s == 5'd0) ? 8'd0 : rs1v[7:0]);
    case (f3[1:0])
      2'b01:   nv = opnd;
      2'b10:   nv = oldv | opnd;
      default: nv = oldv & ~opnd;
    endcase
    @(negedge clk);
    valid_i = 1'b1; insn_i = insn; rs1_val_i = rs1v; fpu_flags_i = flags;
    e.we = ok && (insn[11:7] != 0); e.idx = insn[11:7];
    e.data = {56'b0, oldv}; e.ill = !ok; e.tag = tag;
    exp_q.push_back(e);
    if (ok && (a == 12'h1 || a == 12'h3)) m_flags = nv[4:0];
    else m_flags = m_flags | flags;
    if (ok && (a == 12'h2 || a == 12'h3)) begin
      m_frm = (a == 12'h2) ? nv[2:0] : nv[7:5];
      if (m_frm <= 3'd4) m_rm = m_frm;
    end
    @(negedge clk);
    valid_i = 1'b0; fpu_flags_i = '0; rs1_val_i = '0;
  endtask

  task automatic idle(logic [4:0] flags);
    @(negedge clk);
    fpu_flags_i = flags;
    m_flags = m_flags | flags;
    @(negedge clk);
    fpu_flags_i = '0;
  endtask

  task automatic check_rm(string tag);
    check(tag, "rm_o", {61'b0, rm_o}, {61'b0, m_rm});
    check(tag, "illegal_rm_o", {63'b0, illegal_rm_o}, {63'b0, (m_frm > 3'd4)});
  endtask

  // monitor: compare each issued instruction's same-cycle results
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        check(e.tag, "illegal_insn_o", {63'b0, illegal_insn_o}, {63'b0, e.ill});
        check(e.tag, "rd_we_o", {63'b0, rd_we_o}, {63'b0, e.we});
        if (e.we) begin
          check(e.tag, "rd_idx_o", {59'b0, rd_idx_o}, {59'b0, e.idx});
          check(e.tag, "rd_data_o", rd_data_o, e.data);
        end
      end
    end
  end

  initial begin
    #4000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    check_rm("R10");
    issue("R10", enc(12'h3, 5'd0, 3'b010, 5'd4), 64'hFF, 5'd0);

    // R11: three reference cases starting from mode 001
    issue("R11", enc(12'h2, 5'd1, 3'b101, 5'd0), 0, 0);
    issue("R11", enc(12'h2, 5'd1, 3'b001, 5'd2), 64'h2, 0);
    check_rm("R11");
    issue("R11", enc(12'h2, 5'd1, 3'b101, 5'd0), 0, 0);
    issue("R11", enc(12'h2, 5'd2, 3'b110, 5'd2), 0, 0);
    check_rm("R11");
    issue("R11", enc(12'h2, 5'd1, 3'b101, 5'd0), 0, 0);
    issue("R11", enc(12'h2, 5'd1, 3'b111, 5'd2), 0, 0);
    check_rm("R11");

    // R2: source index 0 forces operand zero, read-only via set
    issue("R2", enc(12'h2, 5'd3, 3'b101, 5'd0), 0, 0);
    issue("R2", enc(12'h2, 5'd0, 3'b010, 5'd5), 64'hFF, 0);
    issue("R2", enc(12'h2, 5'd0, 3'b010, 5'd5), 0, 0);
    // R1 R3: register-form set and clear on fcsr
    issue("R3", enc(12'h3, 5'd7, 3'b010, 5'd9), 64'h0000_0000_0000_0011, 0);
    issue("R1", enc(12'h3, 5'd7, 3'b011, 5'd9), 64'h0000_0000_0000_0001, 0);
    issue("R3", enc(12'h3, 5'd0, 3'b010, 5'd9), 0, 0);

    // R7 R8: reserved code stored, rm_o holds
    issue("R7", enc(12'h2, 5'd6, 3'b101, 5'd1), 0, 0);
    check_rm("R8");
    issue("R7", enc(12'h2, 5'd0, 3'b010, 5'd1), 0, 0);
    issue("R7", enc(12'h2, 5'd4, 3'b101, 5'd1), 0, 0);
    check_rm("R7");

    // R9: accrual and write priority
    issue("R9", enc(12'h1, 5'd0, 3'b111, 5'd0), 64'h1F, 0);
    idle(5'b00101);
    issue("R9", enc(12'h1, 5'd0, 3'b010, 5'd3), 0, 5'b10000);
    issue("R9", enc(12'h1, 5'd0, 3'b010, 5'd3), 0, 0);
    issue("R9", enc(12'h1, 5'd8, 3'b001, 5'd3), 64'h2, 5'b01000);
    issue("R9", enc(12'h1, 5'd0, 3'b010, 5'd3), 0, 0);

    // R4: fcsr packing, upper operand bits ignored
    issue("R4", enc(12'h3, 5'd8, 3'b001, 5'd6), 64'hFFFF_FFFF_FFFF_FFA3, 0);
    issue("R4", enc(12'h3, 5'd0, 3'b010, 5'd6), 0, 0);
    check_rm("R4");
    issue("R4", enc(12'h1, 5'd0, 3'b010, 5'd6), 0, 0);
    issue("R4", enc(12'h3, 5'd8, 3'b011, 5'd6), 64'hE0, 0);
    check_rm("R4");

    // R6: illegal encodings change nothing
    issue("R6", enc(12'h300, 5'd8, 3'b001, 5'd2), 64'h1F, 0);
    issue("R6", 32'h0000_0073, 0, 0);
    issue("R6", enc(12'h3, 5'd8, 3'b100, 5'd2), 64'h1F, 0);
    issue("R6", enc(12'h3, 5'd8, 3'b001, 5'd2) & 32'hFFFF_FF80 | 32'h33, 64'h1F, 0);
    issue("R6", enc(12'h3, 5'd0, 3'b010, 5'd2), 0, 0);

    // R5: rd 0 suppresses write enable but state still updates
    issue("R5", enc(12'h2, 5'd3, 3'b101, 5'd0), 0, 0);
    issue("R5", enc(12'h2, 5'd0, 3'b010, 5'd2), 0, 0);
    check_rm("R5");

    @(negedge clk);
    #10;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule